// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block produces the fetch address for a short in-order pipeline whose instruction set defines one architectural delay slot after every control transfer. Branches and jumps are resolved when they sit in the fetch/decode register. The word that fetch is reading in that same cycle is the delay-slot instruction. It is never discarded: it moves into the fetch/decode register on the next advance, and only the fetch that follows it goes to the branch target. A not-taken branch costs nothing. A taken branch costs nothing either, because the slot does useful work and no bubble is inserted.

The instruction memory answers in the same cycle. `imem_req` qualifies `imem_addr`, and `imem_rdata` holds the word at that address. Each cycle the decode stage reports whether the instruction now held in the fetch/decode register is a control transfer, whether it is taken, and where it goes. A fetch stall freezes the program counter and the fetch/decode register. A redirect that decode reports during a stall is held inside the block until the slot instruction has been handed to decode. If decode flags a control transfer while the fetch/decode register holds a delay-slot instruction, that redirect is illegal: the block raises a one-cycle error flag and ignores it.

Top module: `dslot_pc_seq`

## Requirements
- R1: While `rst` is high on a clock edge (synchronous reset), the next state has `ifid_valid`=0 and `imem_req`=0. On the first cycle after reset is released, `imem_addr` equals `RESET_VEC` (default 0x0000_0000).
- R2: With no redirect, each advance (`imem_req`=1 and `fetch_stall`=0) makes the next fetch address the current one plus `STEP_BYTES` (4).
- R3: On every advance, the fetch/decode register takes `imem_addr` and `imem_rdata` and sets `ifid_valid`=1. So the entry right after a control transfer at address B is always B+4, whether the transfer is taken or not.
- R4: For a taken control transfer (`dec_cti`=1, `dec_taken`=1), the entry after the delay slot has the PC `dec_target` with its two low bits forced to 0.
- R5: For a not-taken control transfer (`dec_cti`=1, `dec_taken`=0), the entry after the delay slot has the PC B+8.
- R6: With `fetch_stall` held at 0, a new fetch/decode entry appears on every cycle, including around taken transfers. No bubble is inserted.
- R7: A clock edge with `imem_req`=1 and `fetch_stall`=1 leaves `imem_addr`, `ifid_valid`, `ifid_pc` and `ifid_instr` unchanged.
- R8: A redirect that decode reports while `fetch_stall`=1 is held. Once the stall ends, the slot and then the redirected entry follow exactly as they would without the stall.
- R9: `dec_cti`=1 while the fetch/decode register holds a delay-slot instruction drives `slot_err` to 1 for exactly one cycle, one cycle later. That redirect has no effect on the entry sequence.
- R10: A synchronous reset discards a redirect that is being held, so fetch then runs sequentially from `RESET_VEC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_stall | input | 1 | Freeze fetch and the fetch/decode register |
| imem_req | output | 1 | Fetch address valid |
| imem_addr | output | PC_W | Fetch address |
| imem_rdata | input | INSTR_W | Instruction word at `imem_addr`, same cycle |
| dec_cti | input | 1 | Instruction in the fetch/decode register is a control transfer |
| dec_taken | input | 1 | Control transfer is taken |
| dec_target | input | PC_W | Control-transfer target address |
| ifid_valid | output | 1 | Fetch/decode entry valid |
| ifid_pc | output | PC_W | PC of the fetch/decode entry |
| ifid_instr | output | INSTR_W | Instruction of the fetch/decode entry |
| slot_err | output | 1 | One-cycle flag: control transfer found in a delay slot |

## Verification
The bench sweeps the branch position, the taken/not-taken outcome and the target, including an unaligned target, and compares each whole entry sequence with a list it computes arithmetically. Three stall patterns run over every such case: no stall, a periodic stall, and a stall held exactly while the branch waits in decode. The first separates a missing or extra bubble from correct zero-penalty redirection. The other two separate a held redirect from one that is lost or applied twice. Further runs place a second branch in the delay slot and assert reset while a redirect is held, which shows that the illegal and discarded redirects leave the sequence untouched.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

   typedef enum logic [1:0] {
      FSRC_HOLD = 2'd0,
      FSRC_SEQ  = 2'd1,
      FSRC_TGT  = 2'd2
   } fetch_src_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/dsq_next_pc.sv
module dsq_next_pc
   import dsq_pkg::*;
#(
   parameter int              PC_W         = 32,
   parameter int              STEP_BYTES   = 4,
   parameter bit              ALIGN_TARGET = 1'b1,
   parameter logic [PC_W-1:0] RESET_VEC    = '0
) (
   input  logic            clk,
   input  logic            rst,
   input  fetch_src_e      src,
   input  logic [PC_W-1:0] tgt_pc,
   output logic [PC_W-1:0] fetch_pc
);
   localparam logic [PC_W-1:0] STEP     = PC_W'(STEP_BYTES);
   localparam logic [PC_W-1:0] LOW_MASK = PC_W'(STEP_BYTES - 1);

   logic [PC_W-1:0] tgt_aligned;
   logic [PC_W-1:0] pc_nxt;

   generate
      if (ALIGN_TARGET) begin : g_align
         assign tgt_aligned = tgt_pc & ~LOW_MASK;
      end else begin : g_raw
         assign tgt_aligned = tgt_pc;
      end
   endgenerate

   always_comb begin
      case (src)
         FSRC_SEQ: pc_nxt = fetch_pc + STEP;
         FSRC_TGT: pc_nxt = tgt_aligned;
         default:  pc_nxt = fetch_pc;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) fetch_pc <= RESET_VEC;
      else     fetch_pc <= pc_nxt;
   end
endmodule

// File: rtl/dsq_ifid_reg.sv
module dsq_ifid_reg #(
   parameter int PC_W    = 32,
   parameter int INSTR_W = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load,
   input  logic [PC_W-1:0]    pc_in,
   input  logic [INSTR_W-1:0] instr_in,
   output logic               valid,
   output logic [PC_W-1:0]    pc,
   output logic [INSTR_W-1:0] instr
);
   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= 1'b0;
         pc    <= '0;
         instr <= '0;
      end else if (load) begin
         valid <= 1'b1;
         pc    <= pc_in;
         instr <= instr_in;
      end
   end
endmodule

// File: rtl/dsq_redirect_ctl.sv
module dsq_redirect_ctl
   import dsq_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            advance,
   input  logic            ifid_valid,
   input  logic            dec_cti,
   input  logic            dec_taken,
   input  logic [PC_W-1:0] dec_target,
   output fetch_src_e      src,
   output logic [PC_W-1:0] tgt_pc,
   output logic            take,
   output logic            in_slot,
   output logic            slot_err
);
   logic            pend_q;
   logic            pend_tk_q;
   logic [PC_W-1:0] pend_tgt_q;
   logic            live_ok;
   logic            illegal;

   assign live_ok = ifid_valid && dec_cti && !in_slot && !pend_q;
   assign illegal = ifid_valid && dec_cti && in_slot;
   assign take    = pend_q ? pend_tk_q : (live_ok && dec_taken);
   assign tgt_pc  = pend_q ? pend_tgt_q : dec_target;

   always_comb begin
      if (!advance)  src = FSRC_HOLD;
      else if (take) src = FSRC_TGT;
      else           src = FSRC_SEQ;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q     <= 1'b0;
         pend_tk_q  <= 1'b0;
         pend_tgt_q <= '0;
         in_slot    <= 1'b0;
         slot_err   <= 1'b0;
      end else begin
         slot_err <= illegal;
         if (advance) begin
            pend_q  <= 1'b0;
            in_slot <= pend_q || live_ok;
         end else if (live_ok) begin
            pend_q     <= 1'b1;
            pend_tk_q  <= dec_taken;
            pend_tgt_q <= dec_target;
         end
      end
   end
endmodule

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq
   import dsq_pkg::*;
#(
   parameter int              PC_W         = 32,
   parameter int              INSTR_W      = 32,
   parameter int              STEP_BYTES   = 4,
   parameter bit              ALIGN_TARGET = 1'b1,
   parameter logic [PC_W-1:0] RESET_VEC    = '0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               fetch_stall,
   output logic               imem_req,
   output logic [PC_W-1:0]    imem_addr,
   input  logic [INSTR_W-1:0] imem_rdata,
   input  logic               dec_cti,
   input  logic               dec_taken,
   input  logic [PC_W-1:0]    dec_target,
   output logic               ifid_valid,
   output logic [PC_W-1:0]    ifid_pc,
   output logic [INSTR_W-1:0] ifid_instr,
   output logic               slot_err
);
   localparam logic [PC_W-1:0] LOW_MASK = PC_W'(STEP_BYTES - 1);

   generate
      if (PC_W < 8 || PC_W > 64) begin : g_bad_pcw
         $error("dslot_pc_seq: PC_W out of range");
      end
      if (!is_pow2(STEP_BYTES)) begin : g_bad_step
         $error("dslot_pc_seq: STEP_BYTES must be a power of two");
      end
      if ((RESET_VEC & LOW_MASK) != '0) begin : g_bad_vec
         $error("dslot_pc_seq: RESET_VEC not aligned");
      end
   endgenerate

   logic            run_q;
   logic            advance;
   logic            redirect_take;
   logic            in_slot;
   logic [PC_W-1:0] redirect_pc;
   fetch_src_e      src;

   always_ff @(posedge clk) begin
      if (rst) run_q <= 1'b0;
      else     run_q <= 1'b1;
   end

   assign imem_req = run_q;
   assign advance  = run_q && !fetch_stall;

   dsq_redirect_ctl #(.PC_W(PC_W)) u_redir (
      .clk        (clk),
      .rst        (rst),
      .advance    (advance),
      .ifid_valid (ifid_valid),
      .dec_cti    (dec_cti),
      .dec_taken  (dec_taken),
      .dec_target (dec_target),
      .src        (src),
      .tgt_pc     (redirect_pc),
      .take       (redirect_take),
      .in_slot    (in_slot),
      .slot_err   (slot_err)
   );

   dsq_next_pc #(
      .PC_W         (PC_W),
      .STEP_BYTES   (STEP_BYTES),
      .ALIGN_TARGET (ALIGN_TARGET),
      .RESET_VEC    (RESET_VEC)
   ) u_npc (
      .clk      (clk),
      .rst      (rst),
      .src      (src),
      .tgt_pc   (redirect_pc),
      .fetch_pc (imem_addr)
   );

   dsq_ifid_reg #(.PC_W(PC_W), .INSTR_W(INSTR_W)) u_ifid (
      .clk      (clk),
      .rst      (rst),
      .load     (advance),
      .pc_in    (imem_addr),
      .instr_in (imem_rdata),
      .valid    (ifid_valid),
      .pc       (ifid_pc),
      .instr    (ifid_instr)
   );
endmodule

// File: rtl/dsq_checker.sv
module dsq_checker #(
   parameter int              PC_W         = 32,
   parameter int              INSTR_W      = 32,
   parameter int              STEP_BYTES   = 4,
   parameter bit              ALIGN_TARGET = 1'b1,
   parameter logic [PC_W-1:0] RESET_VEC    = '0
) (
   input logic               clk,
   input logic               rst,
   input logic               fetch_stall,
   input logic               imem_req,
   input logic [PC_W-1:0]    imem_addr,
   input logic [INSTR_W-1:0] imem_rdata,
   input logic               dec_cti,
   input logic               ifid_valid,
   input logic [PC_W-1:0]    ifid_pc,
   input logic [INSTR_W-1:0] ifid_instr,
   input logic               slot_err,
   input logic               advance,
   input logic               redirect_take,
   input logic [PC_W-1:0]    redirect_pc,
   input logic               in_slot
);
   localparam logic [PC_W-1:0] STEP = PC_W'(STEP_BYTES);
   localparam logic [PC_W-1:0] MASK = ALIGN_TARGET ? ~PC_W'(STEP_BYTES - 1) : '1;

   logic rst_d = 1'b0;

   always @(posedge clk) begin
      if (rst_d) begin
         p_reset_clear_r1 : assert (!ifid_valid && !imem_req && imem_addr == RESET_VEC)
            else $error("reset state wrong");
      end
      rst_d <= rst;
   end

   p_seq_step_r2 : assert property (@(posedge clk) disable iff (rst)
      (advance && !redirect_take) |=> imem_addr == $past(imem_addr) + STEP);

   p_capture_r3 : assert property (@(posedge clk) disable iff (rst)
      advance |=> (ifid_valid && ifid_pc == $past(imem_addr) && ifid_instr == $past(imem_rdata)));

   p_target_r4 : assert property (@(posedge clk) disable iff (rst)
      (advance && redirect_take) |=> imem_addr == ($past(redirect_pc) & MASK));

   p_stall_hold_r7 : assert property (@(posedge clk) disable iff (rst)
      (imem_req && fetch_stall) |=> ($stable(imem_addr) && $stable(ifid_pc) && $stable(ifid_valid)));

   p_slot_err_r9 : assert property (@(posedge clk) disable iff (rst)
      slot_err |-> ($past(dec_cti) && $past(in_slot)));
endmodule

bind dslot_pc_seq dsq_checker #(
   .PC_W         (PC_W),
   .INSTR_W      (INSTR_W),
   .STEP_BYTES   (STEP_BYTES),
   .ALIGN_TARGET (ALIGN_TARGET),
   .RESET_VEC    (RESET_VEC)
) u_chk (
   .clk           (clk),
   .rst           (rst),
   .fetch_stall   (fetch_stall),
   .imem_req      (imem_req),
   .imem_addr     (imem_addr),
   .imem_rdata    (imem_rdata),
   .dec_cti       (dec_cti),
   .ifid_valid    (ifid_valid),
   .ifid_pc       (ifid_pc),
   .ifid_instr    (ifid_instr),
   .slot_err      (slot_err),
   .advance       (advance),
   .redirect_take (redirect_take),
   .redirect_pc   (redirect_pc),
   .in_slot       (in_slot)
);

// File: tb/dslot_pc_seq_test.sv
module dslot_pc_seq_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        fetch_stall = 1'b0;
   logic        imem_req;
   logic [31:0] imem_addr;
   logic [31:0] imem_rdata;
   logic        dec_cti = 1'b0;
   logic        dec_taken = 1'b0;
   logic [31:0] dec_target = '0;
   logic        ifid_valid;
   logic [31:0] ifid_pc;
   logic [31:0] ifid_instr;
   logic        slot_err;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #4 clk = ~clk;

   function automatic logic [31:0] word_at(input logic [31:0] a);
      return {a[31:2], 2'b11} ^ 32'hA5A5_0000;
   endfunction

   assign imem_rdata = word_at(imem_addr);

   dslot_pc_seq uut (
      .clk(clk), .rst(rst), .fetch_stall(fetch_stall),
      .imem_req(imem_req), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .dec_cti(dec_cti), .dec_taken(dec_taken), .dec_target(dec_target),
      .ifid_valid(ifid_valid), .ifid_pc(ifid_pc), .ifid_instr(ifid_instr),
      .slot_err(slot_err)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_fail++;
         $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   task automatic do_reset();
      rst = 1'b1; fetch_stall = 1'b0; dec_cti = 1'b0; dec_taken = 1'b0; dec_target = '0;
      repeat (2) @(negedge clk);
      chk(!ifid_valid, "R1", "ifid_valid in reset", 32'(ifid_valid), 32'd0);
      chk(!imem_req, "R1", "imem_req in reset", 32'(imem_req), 32'd0);
      rst = 1'b0;
      @(negedge clk);
      chk(imem_addr == 32'h0, "R1", "first fetch address", imem_addr, 32'h0);
   endtask

   // b: control-transfer address; bad: slot at b+4 also flagged as a transfer
   task automatic collect(input logic [31:0] b, input bit tk, input logic [31:0] tgt,
                          input int smode, input bit bad, input string over);
      logic [31:0] exp_pc[12];
      logic [31:0] pc = 32'h0;
      logic [31:0] ppc = '0, paddr = '0;
      int k = 0, n = 0, cyc = 0, first = 0, scnt = 0, errs = 0;
      bit pstall = 1'b0, pvalid = 1'b0, s;
      string tag;
      while (k < 12) begin
         exp_pc[k] = pc; k++;
         if (pc == b && k < 12) begin
            exp_pc[k] = b + 32'd4; k++;
            pc = tk ? (tgt & ~32'd3) : b + 32'd8;
         end else pc = pc + 32'd4;
      end
      while (n < 12 && cyc < 80) begin
         @(negedge clk);
         cyc++;
         if (slot_err) errs++;
         if (pstall && pvalid) begin
            chk(ifid_pc == ppc, "R7", "ifid_pc held in stall", ifid_pc, ppc);
            chk(imem_addr == paddr, "R7", "imem_addr held in stall", imem_addr, paddr);
         end
         if (!pstall && ifid_valid) begin
            if (over != "") tag = over;
            else if (n > 0 && exp_pc[n-1] == b) tag = "R3";
            else if (n > 1 && exp_pc[n-2] == b) tag = tk ? "R4" : "R5";
            else tag = "R2";
            if (smode == 2) tag = {"R8/", tag};
            chk(ifid_pc == exp_pc[n], tag, "entry pc", ifid_pc, exp_pc[n]);
            chk(ifid_instr == word_at(exp_pc[n]), tag, "entry instr", ifid_instr, word_at(exp_pc[n]));
            if (n == 0) first = cyc;
            if (smode == 0)
               chk(cyc == first + n, "R6", "entry cycle", 32'(cyc), 32'(first + n));
            n++;
         end
         case (smode)
            1:       s = (cyc % 3 == 1);
            2:       s = ifid_valid && ifid_pc == b && scnt < 2;
            default: s = 1'b0;
         endcase
         if (s && smode == 2) scnt++;
         fetch_stall = s;
         pstall = s; pvalid = ifid_valid; ppc = ifid_pc; paddr = imem_addr;
         dec_cti    = ifid_valid && (ifid_pc == b || (bad && ifid_pc == b + 32'd4));
         dec_taken  = (ifid_pc == b) ? tk : 1'b1;
         dec_target = (ifid_pc == b) ? tgt : 32'h200;
      end
      chk(n == 12, "R6", "entries collected", 32'(n), 32'd12);
      chk(errs == (bad ? 1 : 0), "R9", "slot_err cycles", 32'(errs), bad ? 32'd1 : 32'd0);
      fetch_stall = 1'b0; dec_cti = 1'b0; dec_taken = 1'b0;
   endtask

   initial begin
      logic [31:0] bl[3]  = '{32'd8, 32'd12, 32'd20};
      logic [31:0] tl[2]  = '{32'h40, 32'h103};
      for (int bi = 0; bi < 3; bi++)
         for (int t = 0; t < 2; t++)
            for (int ti = 0; ti < 2; ti++)
               for (int m = 0; m < 3; m++) begin
                  do_reset();
                  collect(bl[bi], t[0], tl[ti], m, 1'b0, "");
               end
      // R9: second transfer in the delay slot is flagged and ignored
      for (int t = 0; t < 2; t++)
         for (int m = 0; m < 3; m += 2) begin
            do_reset();
            collect(32'd12, t[0], 32'h60, m, 1'b1, "");
         end
      // R10: reset while a redirect is held
      do_reset();
      while (!(ifid_valid && ifid_pc == 32'd8)) @(negedge clk);
      fetch_stall = 1'b1; dec_cti = 1'b1; dec_taken = 1'b1; dec_target = 32'h40;
      @(negedge clk);
      rst = 1'b1; fetch_stall = 1'b0; dec_cti = 1'b0; dec_taken = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      collect(32'hFFFF_0000, 1'b0, 32'h0, 0, 1'b0, "R10");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule